// File: doc/BRIEF.md
# Synchronous PWM Channel Update Controller

This block decides when the buffered duty-cycle and period values of a group of PWM channels take effect. The channels in the group update together. A configuration register marks each channel as a member of the group or not. It also selects one of three update policies and sets the condition that raises a write-ready flag and a DMA transfer request. The PWM counter supplies a period-start strobe. Software supplies an unlock strobe and reads a status register. A comparison unit supplies a bank of match inputs.

In manual mode, software fills the double buffers and releases them with an unlock strobe. The release takes effect at the next period start. In the two automatic modes, a down-counter fires an update every N+1 period starts, where N is a programmable 4-bit value. In the DMA-fed mode, the request can follow either that counter or a selected comparison match. The configuration register is write-protected: a write is dropped while either the software or the hardware protect status is high.

Top module: `sync_upd_ctrl`

## Requirements
- R1: After reset, `upd_pulse`, `wr_ready`, `dma_req`, `sync_mask` and `cfg_rdata` are all zero, and the update-period counter holds 0.
- R2: A configuration write that is not blocked stores these fields: bits 3:0 as the channel membership, bits 17:16 as the update mode (0 manual, 1 automatic, 2 DMA-fed, 3 treated as 0), bit 20 as the request source and bits 23:21 as the comparison select. From the next cycle on, `cfg_rdata` returns these fields and reads every other bit as zero.
- R3: A configuration write while `wp_sw` or `wp_hw` is high leaves `cfg_rdata` unchanged.
- R4: In mode 0 (and mode 3), `upd_pulse` is high for one cycle, one cycle after the first `period_start` that comes strictly after a cycle with `unlock` high. A later unlock re-arms this.
- R5: The counter counts down at each `period_start`. A strobe that finds it at 0 is an elapsed event and reloads it from `upd_period`. In modes 1 and 2, `upd_pulse` is high one cycle after each elapsed event.
- R6: In mode 0 (and mode 3), `wr_ready` and `dma_req` are never set.
- R7: In mode 1, `wr_ready` is set one cycle after an elapsed event, and `dma_req` is never set.
- R8: In mode 2 with request source 0, `wr_ready` and `dma_req` are both set one cycle after an elapsed event.
- R9: In mode 2 with request source 1, `wr_ready` and `dma_req` are both set one cycle after a cycle where `cmp_match[select]` is high. Elapsed events do not set them.
- R10: A cycle with `stat_rd` high clears `wr_ready` on the next cycle, unless a set happens in that same cycle.
- R11: A cycle with `dma_ack` high clears `dma_req` on the next cycle, unless a set happens in that same cycle.
- R12: `sync_mask` always equals the stored membership bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback |
| wp_sw | input | 1 | Software write-protect status |
| wp_hw | input | 1 | Hardware write-protect status |
| upd_period | input | 4 | Reload value of the update-period counter |
| period_start | input | 1 | PWM period-start strobe |
| unlock | input | 1 | Software update-unlock strobe |
| cmp_match | input | 8 | Comparison match inputs |
| stat_rd | input | 1 | Status read strobe; clears the write-ready flag |
| dma_ack | input | 1 | DMA acknowledge |
| sync_mask | output | 4 | Synchronous channel membership |
| upd_pulse | output | 1 | Update pulse for the synchronous channels |
| wr_ready | output | 1 | Write-ready flag |
| dma_req | output | 1 | DMA transfer request |

## Verification
The assertions assume that every input is synchronous to `clk` and is sampled as a clean level at each rising edge. They also assume that the mode decoded from `cfg_rdata` in a cycle is the mode that governs that cycle's set decision. This holds because the register updates at the same edge as the flags. The stimulus changes all inputs only on falling edges. It mixes random strobes, protect bits and match vectors across sweeps of every mode and request source, and it never relies on strobes being spaced apart.

// File: rtl/sync_upd_pkg.sv
package sync_upd_pkg;

    localparam int unsigned SYNC_CH   = 4;
    localparam int unsigned PER_W     = 4;
    localparam int unsigned CMP_N     = 8;
    localparam int unsigned SEL_W     = $clog2(CMP_N);
    localparam int unsigned REG_W     = 32;

    localparam int unsigned MODE_LSB  = 16;
    localparam int unsigned SRC_BIT   = 20;
    localparam int unsigned SEL_LSB   = 21;

    typedef enum logic [1:0] {
        UPD_MANUAL = 2'd0,
        UPD_AUTO   = 2'd1,
        UPD_DMA    = 2'd2,
        UPD_RSVD   = 2'd3
    } upd_mode_e;

    typedef struct packed {
        logic [SEL_W-1:0]   sel;
        logic               src_cmp;
        upd_mode_e          mode;
        logic [SYNC_CH-1:0] sync;
    } cfg_t;

    function automatic upd_mode_e eff_mode(input upd_mode_e m);
        return (m == UPD_RSVD) ? UPD_MANUAL : m;
    endfunction

endpackage

// File: rtl/sync_upd_regs.sv
module sync_upd_regs
    import sync_upd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             wp_sw,
    input  logic             wp_hw,
    output cfg_t             cfg_o,
    output logic [REG_W-1:0] rdata_o
);

    typedef struct packed {
        cfg_t cfg;
    } regs_st_t;

    regs_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && !wp_sw && !wp_hw) begin
            st_d.cfg.sync    = wdata[SYNC_CH-1:0];
            st_d.cfg.mode    = upd_mode_e'(wdata[MODE_LSB +: 2]);
            st_d.cfg.src_cmp = wdata[SRC_BIT];
            st_d.cfg.sel     = wdata[SEL_LSB +: SEL_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o                      = '0;
        rdata_o[SYNC_CH-1:0]         = st_q.cfg.sync;
        rdata_o[MODE_LSB +: 2]       = st_q.cfg.mode;
        rdata_o[SRC_BIT]             = st_q.cfg.src_cmp;
        rdata_o[SEL_LSB +: SEL_W]    = st_q.cfg.sel;
    end

    assign cfg_o = st_q.cfg;

endmodule

// File: rtl/sync_upd_timer.sv
module sync_upd_timer
    import sync_upd_pkg::*;
#(
    parameter int unsigned CNT_W = PER_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_start,
    input  logic             unlock,
    input  logic [CNT_W-1:0] reload,
    input  upd_mode_e        mode,
    output logic             elapsed_o,
    output logic             upd_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             upd;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic    elapsed;

    always_comb begin
        st_d    = st_q;
        elapsed = period_start && (st_q.cnt == '0);
        if (period_start) begin
            st_d.cnt = elapsed ? reload : st_q.cnt - 1'b1;
        end
        st_d.armed = unlock || (st_q.armed && !period_start);
        if (eff_mode(mode) == UPD_MANUAL) st_d.upd = period_start && st_q.armed;
        else                              st_d.upd = elapsed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign elapsed_o = elapsed;
    assign upd_o     = st_q.upd;

endmodule

// File: rtl/sync_upd_flags.sv
module sync_upd_flags
    import sync_upd_pkg::*;
#(
    parameter int unsigned NCMP = CMP_N
) (
    input  logic            clk,
    input  logic            rst_n,
    input  cfg_t            cfg,
    input  logic            elapsed,
    input  logic [NCMP-1:0] cmp_match,
    input  logic            stat_rd,
    input  logic            dma_ack,
    output logic            wr_ready_o,
    output logic            dma_req_o
);

    typedef struct packed {
        logic rdy;
        logic req;
    } flg_st_t;

    flg_st_t st_d, st_q;
    logic    set_rdy, set_req, hit;

    always_comb begin
        hit     = cmp_match[cfg.sel];
        set_rdy = 1'b0;
        set_req = 1'b0;
        case (eff_mode(cfg.mode))
            UPD_AUTO: set_rdy = elapsed;
            UPD_DMA: begin
                set_rdy = cfg.src_cmp ? hit : elapsed;
                set_req = set_rdy;
            end
            default: ;
        endcase
        st_d.rdy = set_rdy || (st_q.rdy && !stat_rd);
        st_d.req = set_req || (st_q.req && !dma_ack);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_ready_o = st_q.rdy;
    assign dma_req_o  = st_q.req;

endmodule

// File: rtl/sync_upd_ctrl.sv
module sync_upd_ctrl
    import sync_upd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [REG_W-1:0]   cfg_wdata,
    output logic [REG_W-1:0]   cfg_rdata,
    input  logic               wp_sw,
    input  logic               wp_hw,
    input  logic [PER_W-1:0]   upd_period,
    input  logic               period_start,
    input  logic               unlock,
    input  logic [CMP_N-1:0]   cmp_match,
    input  logic               stat_rd,
    input  logic               dma_ack,
    output logic [SYNC_CH-1:0] sync_mask,
    output logic               upd_pulse,
    output logic               wr_ready,
    output logic               dma_req
);

    cfg_t cfg;
    logic elapsed;

    sync_upd_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wdata   (cfg_wdata),
        .wp_sw   (wp_sw),
        .wp_hw   (wp_hw),
        .cfg_o   (cfg),
        .rdata_o (cfg_rdata)
    );

    sync_upd_timer #(.CNT_W(PER_W)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_start (period_start),
        .unlock       (unlock),
        .reload       (upd_period),
        .mode         (cfg.mode),
        .elapsed_o    (elapsed),
        .upd_o        (upd_pulse)
    );

    sync_upd_flags #(.NCMP(CMP_N)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg),
        .elapsed    (elapsed),
        .cmp_match  (cmp_match),
        .stat_rd    (stat_rd),
        .dma_ack    (dma_ack),
        .wr_ready_o (wr_ready),
        .dma_req_o  (dma_req)
    );

    assign sync_mask = cfg.sync;

endmodule

// File: rtl/sync_upd_chk.sv
module sync_upd_chk
    import sync_upd_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic             wp_sw,
    input logic             wp_hw,
    input logic [REG_W-1:0] cfg_rdata,
    input logic             period_start,
    input logic             stat_rd,
    input logic             upd_pulse,
    input logic             wr_ready,
    input logic             dma_req
);

    logic [1:0] m;
    logic       man;
    assign m   = cfg_rdata[MODE_LSB +: 2];
    assign man = (m == 2'd0) || (m == 2'd3);

    // R3
    wp_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (wp_sw || wp_hw)) |=> $stable(cfg_rdata));

    // R5
    upd_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |=> !upd_pulse);

    // R6
    manual_no_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        man |=> (!$rose(wr_ready) && !$rose(dma_req)));

    // R7
    auto_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m == 2'd1) |=> !$rose(dma_req));

    // R10
    rd_clears_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (man && stat_rd) |=> !wr_ready);

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & ~32'h00F3_000F) == '0);

endmodule

bind sync_upd_ctrl sync_upd_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr       (cfg_wr),
    .wp_sw        (wp_sw),
    .wp_hw        (wp_hw),
    .cfg_rdata    (cfg_rdata),
    .period_start (period_start),
    .stat_rd      (stat_rd),
    .upd_pulse    (upd_pulse),
    .wr_ready     (wr_ready),
    .dma_req      (dma_req)
);

// File: tb/sync_upd_ctrl_tb.sv
`timescale 1ns/100ps
module sync_upd_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        wp_sw = 1'b0, wp_hw = 1'b0;
    logic [3:0]  upd_period = 4'd2;
    logic        period_start = 1'b0, unlock = 1'b0;
    logic [7:0]  cmp_match = '0;
    logic        stat_rd = 1'b0, dma_ack = 1'b0;
    logic [3:0]  sync_mask;
    logic        upd_pulse, wr_ready, dma_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sync_upd_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .wp_sw(wp_sw), .wp_hw(wp_hw),
        .upd_period(upd_period), .period_start(period_start), .unlock(unlock),
        .cmp_match(cmp_match), .stat_rd(stat_rd), .dma_ack(dma_ack),
        .sync_mask(sync_mask), .upd_pulse(upd_pulse), .wr_ready(wr_ready),
        .dma_req(dma_req)
    );

    // behavioural reference, advanced at each rising edge
    int  r_sync, r_mode, r_src, r_sel;
    int  r_cnt;
    bit  r_arm, r_upd, r_rdy, r_req;
    int  last_eff, last_src;
    bit  last_rd, last_ack;

    function automatic int model_word();
        return r_sync | (r_mode << 16) | (r_src << 20) | (r_sel << 21);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            r_sync = 0; r_mode = 0; r_src = 0; r_sel = 0; r_cnt = 0;
            r_arm = 0; r_upd = 0; r_rdy = 0; r_req = 0;
            last_eff = 0; last_src = 0; last_rd = 0; last_ack = 0;
        end else begin
            int  eff;
            bit  el, s_rdy, s_req;
            eff = (r_mode == 3) ? 0 : r_mode;
            el  = period_start && (r_cnt == 0);
            if (eff == 0) r_upd = period_start && r_arm;
            else          r_upd = el;
            s_rdy = 0; s_req = 0;
            if (eff == 1) s_rdy = el;
            if (eff == 2) begin
                s_rdy = r_src ? cmp_match[r_sel] : el;
                s_req = s_rdy;
            end
            r_rdy = s_rdy || (r_rdy && !stat_rd);
            r_req = s_req || (r_req && !dma_ack);
            if (period_start) r_cnt = el ? int'(upd_period) : r_cnt - 1;
            r_arm = unlock || (r_arm && !period_start);
            last_eff = eff; last_src = r_src; last_rd = stat_rd; last_ack = dma_ack;
            if (cfg_wr && !wp_sw && !wp_hw) begin
                r_sync = cfg_wdata[3:0];
                r_mode = cfg_wdata[17:16];
                r_src  = cfg_wdata[20];
                r_sel  = cfg_wdata[23:21];
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string rdy_tag();
        if (last_rd) return "R10 wr_ready";
        case (last_eff)
            0: return "R6 wr_ready";
            1: return "R7 wr_ready";
            default: return last_src ? "R9 wr_ready" : "R8 wr_ready";
        endcase
    endfunction

    function automatic string req_tag();
        if (last_ack) return "R11 dma_req";
        case (last_eff)
            0: return "R6 dma_req";
            1: return "R7 dma_req";
            default: return last_src ? "R9 dma_req" : "R8 dma_req";
        endcase
    endfunction

    bit compare_on = 0;
    always @(negedge clk) begin
        if (compare_on && rst_n) begin
            check("R2 cfg_rdata", cfg_rdata, model_word());
            check("R12 sync_mask", sync_mask, r_sync);
            check(last_eff == 0 ? "R4 upd_pulse" : "R5 upd_pulse", upd_pulse, r_upd);
            check(rdy_tag(), wr_ready, r_rdy);
            check(req_tag(), dma_req, r_req);
        end
    end

    task automatic write_cfg(input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = d; wp_sw = 1'b0; wp_hw = 1'b0;
        period_start = 1'b0; unlock = 1'b0; stat_rd = 1'b0; dma_ack = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic run_random(input int cycles, input int ps_div);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            period_start = ($urandom % ps_div) == 0;
            unlock       = ($urandom % 9) == 0;
            cmp_match    = 8'($urandom) & 8'($urandom);
            stat_rd      = ($urandom % 6) == 0;
            dma_ack      = ($urandom % 4) == 0;
            wp_sw        = ($urandom % 8) == 0;
            wp_hw        = ($urandom % 8) == 0;
            cfg_wr       = ($urandom % 120) == 0;
            cfg_wdata    = $urandom;
            if (($urandom % 200) == 0) upd_period = 4'($urandom);
        end
        @(negedge clk);
        cfg_wr = 1'b0; period_start = 1'b0; unlock = 1'b0;
        stat_rd = 1'b0; dma_ack = 1'b0; wp_sw = 1'b0; wp_hw = 1'b0;
    endtask

    initial begin
        #(5 * 60000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 upd_pulse", upd_pulse, 0);
        check("R1 wr_ready", wr_ready, 0);
        check("R1 dma_req", dma_req, 0);
        check("R1 cfg_rdata", cfg_rdata, 0);
        check("R1 sync_mask", sync_mask, 0);
        rst_n = 1'b1;
        @(negedge clk);
        compare_on = 1;

        // R3 directed: blocked write leaves readback untouched
        write_cfg(32'h00F3_000A);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = 32'h0000_0005; wp_hw = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; wp_hw = 1'b0;
        check("R3 cfg_rdata", cfg_rdata, 32'h00F3_000A);

        // R4 directed: unlock then strobe gives one pulse
        write_cfg(32'h0000_0003);
        repeat (4) @(negedge clk);
        unlock = 1'b1;
        @(negedge clk);
        unlock = 1'b0;
        @(negedge clk);
        period_start = 1'b1;
        @(negedge clk);
        period_start = 1'b0;
        check("R4 directed pulse", upd_pulse, 1);
        @(negedge clk);
        check("R4 single pulse", upd_pulse, 0);

        for (int mode = 0; mode < 4; mode++) begin
            for (int src = 0; src < 2; src++) begin
                for (int pd = 1; pd < 5; pd += 2) begin
                    write_cfg(32'(mode << 16) | 32'(src << 20) |
                              32'(((mode * 3 + src) % 8) << 21) | 32'(mode + 5 * src));
                    upd_period = 4'(pd * 3);
                    run_random(700, pd + 1);
                end
            end
        end

        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule